// File: doc/BRIEF.md
# Byte-Serial AES-128 Encryption Engine

This block encrypts one 128-bit block under a 128-bit key with the AES-128 cipher. It is built for minimum area. The working state sits in a single 16-byte register file, and the round keys are expanded on the fly in a second 16-byte key register. One S-box, built as logic, is shared in time between substitution of the data bytes and the word substitution of the key schedule.

A caller presents the plaintext and the key and raises `start` for one cycle. The engine then runs a fixed schedule:

- one load cycle, which performs the initial key addition;
- ten rounds of 35 cycles each;
- one output cycle.

It then pulses `done`. From that point the ciphertext stays on `ciphertext` until the next accepted start.

Each round follows the same cycle order:

- **Cycles 0..3:** the S-box serves the key. The rotated last key word is substituted, and the round constant is added to the first byte.
- **Cycle 4:** the remaining key words are chained.
- **Cycles 4..19:** the S-box serves the sixteen data bytes in index order.
- **Cycle 20:** the row shift is applied as one in-place permutation of the register file.
- **Cycles 21..24:** column mixing and round-key addition are done one column per cycle. Column mixing is skipped in the last round.
- **Cycles 25..34:** padding.

Top module: `aes128_byte_serial`

## Requirements
- R1: A single S-box is used for both jobs. It serves the key schedule in round cycles 0..3, and the data state is not modified in those cycles. It serves data byte k in round cycle 4+k. The key register does not change after round cycle 4 of any round.
- R2: The edge that samples an accepted `start` counts as edge 1. `done` is high right after edge 352.
- R3: For an accepted start, `ciphertext` equals the AES-128 encryption of `plaintext` under `key` when `done` is high. Byte 0 of each 128-bit port is bits [127:120], and byte 15 is bits [7:0]. With key 000102030405060708090a0b0c0d0e0f and plaintext 00112233445566778899aabbccddeeff, the ciphertext is 69c4e0d86a7b0430d8cdb78070b4c55a.
- R4: While a block is in progress, `start` has no effect. The running result, its timing and the number of `done` pulses are unchanged, and changes on `plaintext` and `key` are also ignored.
- R5: `done` is high for exactly one cycle per accepted block.
- R6: `ciphertext` holds its value from `done` until the next accepted start. A start raised in the cycle in which `done` is high is accepted.
- R7: The round constant is 0x01 in round 1. It is doubled in GF(2^8) with reduction by 0x1B each round, so round 10 uses 0x36.
- R8: Rounds 1 to 9 apply column mixing with the polynomial 0x11B. Round 10 leaves it out.
- R9: After a synchronous active-low reset, `done` is low, `ciphertext` is all zero, and the engine is idle and ready to accept a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Start pulse; sampled only while idle |
| plaintext | input | 128 | Block to encrypt, byte 0 in [127:120] |
| key | input | 128 | Cipher key, byte 0 in [127:120] |
| ciphertext | output | 128 | Result, valid from `done` until the next accepted start |
| done | output | 1 | One-cycle pulse when the result is ready |

## Verification
The `done` pulse of one block and the acceptance of the next start can fall in the same cycle. In that cycle the engine must still present the finished ciphertext and already take the new operands. The bench provokes this by raising `start` with a new vector in the very cycle it sees `done`. The scoreboard then judges both results: the first block's ciphertext is compared at its pulse, and the second block must return its correct ciphertext exactly 352 edges after the start.

// File: rtl/aes_byte_pkg.sv
// Shared constants, types and GF(2^8) helpers for the byte-serial AES core.
// Assumes the AES field polynomial x^8+x^4+x^3+x+1 (0x11B).
package aes_byte_pkg;

    localparam int STATE_BYTES = 16;
    localparam int WORD_BYTES  = 4;
    localparam int NUM_COLS    = STATE_BYTES / WORD_BYTES;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_OUT  = 2'd2
    } seq_mode_t;

    // Multiply by x in GF(2^8).
    function automatic logic [7:0] gf_xtime(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    // General multiply in GF(2^8), shift-and-add.
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] aa;
        acc = 8'h00;
        aa  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ aa;
            aa = gf_xtime(aa);
        end
        return acc;
    endfunction

    // Multiplicative inverse as a^254 (maps 0 to 0).
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] r;
        r = 8'h01;
        for (int i = 7; i >= 0; i--) begin
            r = gf_mul(r, r);
            if (i != 0) r = gf_mul(r, a);
        end
        return r;
    endfunction

    // Rotate a byte left by n.
    function automatic logic [7:0] rotl8(input logic [7:0] b, input int n);
        return (b << n) | (b >> (8 - n));
    endfunction

    // Forward substitution: inverse followed by the affine map.
    function automatic logic [7:0] sbox_fwd(input logic [7:0] a);
        logic [7:0] v;
        v = gf_inv(a);
        return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
    endfunction

    // Round constant used in round n (n >= 1).
    function automatic logic [7:0] rcon_at(input int n);
        logic [7:0] c;
        c = 8'h01;
        for (int i = 1; i < n; i++) c = gf_xtime(c);
        return c;
    endfunction

endpackage

// File: rtl/aes_sbox_unit.sv
// The single substitution unit of the core, purely combinational.
// Assumes the caller multiplexes key and data bytes onto sub_in.
module aes_sbox_unit (
    input  logic [7:0] sub_in,
    output logic [7:0] sub_out
);
    import aes_byte_pkg::*;

    // Field inversion plus affine transform.
    always_comb sub_out = sbox_fwd(sub_in);

endmodule

// File: rtl/aes_mixcol_unit.sv
// Column mixer for one 4-byte column; row 0 in [31:24].
// Assumes bypass is raised for the final round, which passes the column through.
module aes_mixcol_unit (
    input  logic [31:0] col_in,
    input  logic        bypass,
    output logic [31:0] col_out
);
    import aes_byte_pkg::*;

    logic [7:0] a [4];
    logic [7:0] m [4];

    genvar r;
    generate
        for (r = 0; r < 4; r++) begin : g_row
            assign a[r] = col_in[31-8*r -: 8];
            // Row r: 2*a[r] ^ 3*a[r+1] ^ a[r+2] ^ a[r+3].
            assign m[r] = gf_xtime(a[r]) ^ gf_xtime(a[(r+1)%4]) ^ a[(r+1)%4]
                        ^ a[(r+2)%4] ^ a[(r+3)%4];
            assign col_out[31-8*r -: 8] = bypass ? a[r] : m[r];
        end
    endgenerate

endmodule

// File: rtl/aes_round_seq.sv
// Round and cycle sequencer: idle, ROUNDS x ROUND_CYCLES run cycles, one output cycle.
// Assumes start is a level sampled only while idle; done is a registered pulse.
module aes_round_seq #(
    parameter  int ROUNDS       = 10,
    parameter  int ROUND_CYCLES = 35,
    localparam int PH_W         = $clog2(ROUND_CYCLES),
    localparam int RD_W         = $clog2(ROUNDS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    output logic            load,
    output logic            run,
    output logic            busy,
    output logic [PH_W-1:0] phase,
    output logic [RD_W-1:0] round,
    output logic            done
);
    import aes_byte_pkg::*;

    localparam logic [PH_W-1:0] PH_LAST = PH_W'(ROUND_CYCLES - 1);
    localparam logic [RD_W-1:0] RD_LAST = RD_W'(ROUNDS);
    localparam int              TOTAL   = ROUNDS * ROUND_CYCLES + 2;

    seq_mode_t mode;

    assign load = (mode == SEQ_IDLE) && start;
    assign run  = (mode == SEQ_RUN);
    assign busy = (mode != SEQ_IDLE);

    // Advance phase and round counters and emit the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode  <= SEQ_IDLE;
            phase <= '0;
            round <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (mode)
                SEQ_IDLE: if (start) begin
                    mode  <= SEQ_RUN;
                    phase <= '0;
                    round <= RD_W'(1);
                end
                SEQ_RUN: if (phase == PH_LAST) begin
                    phase <= '0;
                    if (round == RD_LAST) mode <= SEQ_OUT;
                    else                  round <= round + 1'b1;
                end else begin
                    phase <= phase + 1'b1;
                end
                SEQ_OUT: begin
                    mode <= SEQ_IDLE;
                    done <= 1'b1;
                end
                default: mode <= SEQ_IDLE;
            endcase
        end
    end

    // Checker-only latency counter: edges since the accepting edge.
    logic [15:0] lat_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)    lat_cnt <= '0;
        else if (load) lat_cnt <= 16'd1;
        else if (busy) lat_cnt <= lat_cnt + 16'd1;
    end

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_cnt == 16'(TOTAL)));                                          // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                            // R5
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (run && start && phase != PH_LAST) |=> (run && phase == $past(phase) + 1'b1)); // R4

endmodule

// File: rtl/aes128_byte_serial.sv
// Byte-serial AES-128 encryption top: 16-byte state, 16-byte key, one S-box.
// Assumes a start pulse while idle; result held on ciphertext from done to next start.
module aes128_byte_serial #(
    parameter int ROUNDS       = 10,
    parameter int ROUND_CYCLES = 35
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [127:0] plaintext,
    input  logic [127:0] key,
    output logic [127:0] ciphertext,
    output logic         done
);
    import aes_byte_pkg::*;

    localparam int PH_W = $clog2(ROUND_CYCLES);
    localparam int RD_W = $clog2(ROUNDS + 1);
    localparam logic [PH_W-1:0] PH_SUB0  = PH_W'(WORD_BYTES);
    localparam logic [PH_W-1:0] PH_SUBL  = PH_W'(WORD_BYTES + STATE_BYTES - 1);
    localparam logic [PH_W-1:0] PH_SHIFT = PH_W'(WORD_BYTES + STATE_BYTES);
    localparam logic [PH_W-1:0] PH_MIX0  = PH_W'(WORD_BYTES + STATE_BYTES + 1);
    localparam logic [PH_W-1:0] PH_MIXL  = PH_W'(WORD_BYTES + STATE_BYTES + NUM_COLS);
    localparam logic [PH_W-1:0] PH_LAST  = PH_W'(ROUND_CYCLES - 1);
    localparam logic [7:0]      RCON_END = rcon_at(ROUNDS);

    logic            load, run, busy;
    logic [PH_W-1:0] phase;
    logic [RD_W-1:0] round;

    logic [7:0] st    [STATE_BYTES];
    logic [7:0] st_nx [STATE_BYTES];
    logic [7:0] kw    [STATE_BYTES];
    logic [7:0] kw_nx [STATE_BYTES];
    logic [7:0] pt_b  [STATE_BYTES];
    logic [7:0] key_b [STATE_BYTES];
    logic [7:0] rcon, rcon_nx;
    logic [7:0] sb_in, sb_out;
    logic [1:0] col_sel;
    logic [3:0] sub_idx;
    logic [31:0] col_in, col_out;
    logic [127:0] kw_flat;

    aes_round_seq #(.ROUNDS(ROUNDS), .ROUND_CYCLES(ROUND_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .load(load), .run(run),
        .busy(busy), .phase(phase), .round(round), .done(done)
    );

    aes_sbox_unit u_sbox (.sub_in(sb_in), .sub_out(sb_out));

    aes_mixcol_unit u_mix (
        .col_in(col_in), .bypass(round == RD_W'(ROUNDS)), .col_out(col_out)
    );

    genvar g;
    generate
        for (g = 0; g < STATE_BYTES; g++) begin : g_bytes
            assign pt_b[g]  = plaintext[127-8*g -: 8];
            assign key_b[g] = key[127-8*g -: 8];
            assign ciphertext[127-8*g -: 8] = st[g];
            assign kw_flat[127-8*g -: 8]    = kw[g];
        end
    endgenerate

    // Decode the byte and column addressed by the current phase.
    always_comb begin
        sub_idx = 4'(phase - PH_SUB0);
        col_sel = 2'(phase - PH_MIX0);
        col_in  = {st[{col_sel, 2'd0}], st[{col_sel, 2'd1}],
                   st[{col_sel, 2'd2}], st[{col_sel, 2'd3}]};
    end

    // Share the S-box: rotated last key word first, then data bytes.
    always_comb begin
        if (phase < PH_SUB0) sb_in = kw[{2'b11, phase[1:0] + 2'd1}];
        else                 sb_in = st[sub_idx];
    end

    // Next-state of state, key and round constant for the current phase.
    always_comb begin
        st_nx   = st;
        kw_nx   = kw;
        rcon_nx = rcon;
        if (load) begin
            for (int i = 0; i < STATE_BYTES; i++) begin
                st_nx[i] = pt_b[i] ^ key_b[i];
                kw_nx[i] = key_b[i];
            end
            rcon_nx = 8'h01;
        end else if (run) begin
            if (phase < PH_SUB0)
                kw_nx[{2'b00, phase[1:0]}] = kw[{2'b00, phase[1:0]}] ^ sb_out
                                           ^ ((phase == '0) ? rcon : 8'h00);
            if (phase == PH_SUB0) begin
                for (int r = 0; r < WORD_BYTES; r++) begin
                    kw_nx[4+r]  = kw[4+r]  ^ kw[r];
                    kw_nx[8+r]  = kw[8+r]  ^ kw_nx[4+r];
                    kw_nx[12+r] = kw[12+r] ^ kw_nx[8+r];
                end
            end
            if (phase >= PH_SUB0 && phase <= PH_SUBL)
                st_nx[sub_idx] = sb_out;
            if (phase == PH_SHIFT) begin
                for (int c = 0; c < NUM_COLS; c++)
                    for (int r = 0; r < WORD_BYTES; r++)
                        st_nx[4*c+r] = st[4*((c+r)%4)+r];
            end
            if (phase >= PH_MIX0 && phase <= PH_MIXL) begin
                for (int r = 0; r < WORD_BYTES; r++)
                    st_nx[{col_sel, 2'(r)}] = col_out[31-8*r -: 8] ^ kw[{col_sel, 2'(r)}];
            end
            if (phase == PH_LAST) rcon_nx = gf_xtime(rcon);
        end
    end

    // Register the working state, key and round constant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STATE_BYTES; i++) begin
                st[i] <= 8'h00;
                kw[i] <= 8'h00;
            end
            rcon <= 8'h01;
        end else begin
            st   <= st_nx;
            kw   <= kw_nx;
            rcon <= rcon_nx;
        end
    end

    AST_DATA_QUIET_IN_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (run && phase < PH_SUB0) |=> $stable(ciphertext));      // R1
    AST_KEY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (run && phase > PH_SUB0) |=> $stable(kw_flat));         // R1
    AST_CT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(ciphertext));             // R6
    AST_RCON_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (run && round == RD_W'(1)) |-> (rcon == 8'h01));        // R7
    AST_RCON_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
        (run && round == RD_W'(ROUNDS)) |-> (rcon == RCON_END)); // R7

endmodule

// File: tb/aes128_byte_serial_test.sv
// Scoreboard bench: the driver queues expected results, the monitor compares at done.
module aes128_byte_serial_test;

    localparam int CLK_PERIOD = 10;
    localparam int LATENCY    = 352;
    localparam int WATCHDOG   = 20000;

    localparam logic [127:0] K1 = 128'h000102030405060708090a0b0c0d0e0f;
    localparam logic [127:0] P1 = 128'h00112233445566778899aabbccddeeff;
    localparam logic [127:0] C1 = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
    localparam logic [127:0] K2 = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    localparam logic [127:0] P2 = 128'h3243f6a8885a308d313198a2e0370734;
    localparam logic [127:0] C2 = 128'h3925841d02dc09fbdc118597196a0b32;
    localparam logic [127:0] K3 = 128'h0;
    localparam logic [127:0] P3 = 128'h0;
    localparam logic [127:0] C3 = 128'h66e94bd4ef8a2c3b884cfa59ca342b2e;

    typedef struct {
        logic [127:0] ct;
        int           start_cyc;
    } exp_item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [127:0] plaintext = '0;
    logic [127:0] key = '0;
    logic [127:0] ciphertext;
    logic         done;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int done_seen = 0;
    int launched = 0;
    logic prev_done = 1'b0;
    exp_item_t sb_q[$];

    aes128_byte_serial uut (
        .clk(clk), .rst_n(rst_n), .start(start), .plaintext(plaintext),
        .key(key), .ciphertext(ciphertext), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // Driver: called at a negedge; raise start for one cycle and queue the expectation.
    task automatic launch(input logic [127:0] k, input logic [127:0] p, input logic [127:0] c);
        exp_item_t it;
        key       = k;
        plaintext = p;
        start     = 1'b1;
        it.ct        = c;
        it.start_cyc = cyc + 1;
        sb_q.push_back(it);
        launched++;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (!done) @(negedge clk);
    endtask

    // Monitor: pop and compare each result as done appears.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done && prev_done)
                check(1'b0, "R5", "done high two cycles", 128'd1, 128'd0);
            if (done) begin
                done_seen++;
                if (sb_q.size() == 0) begin
                    check(1'b0, "R4", "done with no accepted start", 128'd1, 128'd0);
                end else begin
                    exp_item_t it;
                    it = sb_q.pop_front();
                    check(ciphertext == it.ct, "R3/R7/R8", "ciphertext", ciphertext, it.ct);
                    check(cyc - it.start_cyc + 1 == LATENCY, "R2", "latency edges",
                          128'(cyc - it.start_cyc + 1), 128'(LATENCY));
                end
            end
        end
        prev_done = done;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        check(1'b0, "WATCHDOG", "run did not finish", 128'd0, 128'd1);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check(done == 1'b0, "R9", "done after reset", 128'(done), 128'd0);
        check(ciphertext == 128'd0, "R9", "ciphertext after reset", ciphertext, 128'd0);

        // R3 known answer, R2 latency, then R6 hold and R5 pulse width
        launch(K1, P1, C1);
        wait_done();
        @(negedge clk);
        check(done == 1'b0, "R5", "done one cycle only", 128'(done), 128'd0);
        key = K2;
        plaintext = P2;
        repeat (25) @(negedge clk);
        check(ciphertext == C1, "R6", "ciphertext held while idle", ciphertext, C1);
        check(done == 1'b0, "R6", "no done while idle", 128'(done), 128'd0);

        // R4: start and operand changes during a run are ignored
        launch(K2, P2, C2);
        repeat (100) @(negedge clk);
        key = K3;
        plaintext = P3;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (150) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        check(ciphertext == C2, "R4", "result after ignored starts", ciphertext, C2);

        // R6: new start in the same cycle as done is accepted (back to back)
        launch(K3, P3, C3);
        wait_done();
        check(ciphertext == C3, "R6", "back-to-back result", ciphertext, C3);
        launch(K1, P1, C1);
        wait_done();

        // R4: no spurious done afterwards
        repeat (500) @(negedge clk);
        check(done_seen == launched, "R4", "done pulse count",
              128'(done_seen), 128'(launched));
        check(sb_q.size() == 0, "R2", "pending results", 128'(sb_q.size()), 128'd0);
        check(ciphertext == C1, "R6", "final ciphertext held", ciphertext, C1);
        summary();
        $finish;
    end

endmodule